// File: doc/BRIEF.md
# Bus Ready and Off-Board Request Logic

This block sits beside a processor with a single wait-state input and decides, for each access, whether the target is local or remote. Local targets keep the ready line high so that the access completes without a wait state. Local targets are a boot ROM whose size is set by a strap input, a 512-byte RAM window and a 16-port I/O window. Any other address is treated as remote and must go out over a shared system bus.

For a remote access the block pulls ready low at once and raises an active-low bus request. While it requests, it drives the priority-out line high so that lower-priority masters are held off. It waits for an active-low grant, then enables the address and data drivers. On a read it turns the data transceivers inward. Ready stays low until the remote device answers with an active-low transfer acknowledge.

Once the bus is held, it is kept until that acknowledge has been seen. After the acknowledge, all bus outputs return to idle on the clock that follows the end of the command. Priority resolution between masters is handled elsewhere.

Top module: `busrdy_ctrl`

## Requirements
- R1: A memory access (io_sel=0) with rd_n or wr_n low and an address below 0x0800 (rom_big=0) or below 0x1000 (rom_big=1) holds cpu_ready high in the same cycle and raises no request.
- R2: A memory access inside the 512-byte window starting at RAM_BASE (default 0x3E00, so 0x3E00 to 0x3FFF) holds cpu_ready high and raises no request.
- R3: An I/O access (io_sel=1) whose address bits [7:4] equal those of IO_BASE (default 0xE0) holds cpu_ready high. The ROM and RAM windows do not apply to I/O accesses.
- R4: Any other active command drives cpu_ready low in the same cycle. From the next clock, breq_n is low and bpro_n is high.
- R5: drv_en_n goes low on the clock after bus_gnt_n is sampled low while the request is pending. While waiting for the grant, cpu_ready stays low.
- R6: With the drivers enabled, cpu_ready stays low while xfer_ack_n is high. It goes high in the same cycle that xfer_ack_n is low, and stays high from then until the command ends.
- R7: rd_dir is high while the drivers are enabled for a read (rd_n low at request start) and low for a write.
- R8: Once the drivers are enabled, they and the request remain asserted until xfer_ack_n has been sampled low, even if the command is removed earlier.
- R9: After the acknowledge, breq_n, bpro_n, drv_en_n and rd_dir return to idle levels (1, 0, 1, 0) on the clock after the command ends, and not before.
- R10: After reset, and whenever no command is active and no bus cycle is held, the outputs are at idle levels and cpu_ready is high.
- R11: If the command is removed before the grant arrives, breq_n returns high on the next clock and the drivers are never enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Processor address (I/O port number in bits [7:0]) |
| io_sel | input | 1 | 1 = I/O space, 0 = memory space |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| rom_big | input | 1 | ROM size strap: 0 = 2K window, 1 = 4K window |
| bus_gnt_n | input | 1 | Active-low bus grant from the priority network |
| xfer_ack_n | input | 1 | Active-low transfer acknowledge from the remote device |
| cpu_ready | output | 1 | Ready to the processor, low inserts wait states |
| breq_n | output | 1 | Active-low bus request |
| bpro_n | output | 1 | Priority out, high while this master requests |
| drv_en_n | output | 1 | Active-low enable for address and data drivers |
| rd_dir | output | 1 | High turns data transceivers inward for a read |

## Verification
A wrong decode shows in the same cycle as the command: cpu_ready is low for a local address, or high for a remote one. On the next clock, breq_n shows the same error. A handshake state that is stuck, skipped or released early shows within one clock. The symptom is drivers enabled without a grant, drivers dropped before the acknowledge, or a request that lingers after the command has ended. A wrongly captured transfer direction shows on rd_dir as soon as the drivers turn on.

// File: rtl/busrdy_pkg.sv
package busrdy_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2,
    ST_DONE = 2'd3
  } busrdy_st_e;

endpackage

// File: rtl/busrdy_decode.sv
module busrdy_decode #(
  parameter int              ADDR_W    = 16,
  parameter int              IO_W      = 8,
  parameter int              ROM_SMALL = 2048,
  parameter int              ROM_LARGE = 4096,
  parameter int              RAM_BYTES = 512,
  parameter logic [ADDR_W-1:0] RAM_BASE = 16'h3E00,
  parameter int              IO_SPAN   = 16,
  parameter logic [IO_W-1:0] IO_BASE   = 8'hE0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_sel,
  input  logic              rom_big,
  output logic              hit
);

  localparam int RAM_LSB = $clog2(RAM_BYTES);
  localparam int IO_LSB  = $clog2(IO_SPAN);
  localparam logic [ADDR_W-1:0] ROM_LIM_S = ADDR_W'(ROM_SMALL);
  localparam logic [ADDR_W-1:0] ROM_LIM_L = ADDR_W'(ROM_LARGE);

  logic rom_hit;
  logic ram_hit;
  logic io_hit;

  always_comb begin
    rom_hit = !io_sel && (addr < (rom_big ? ROM_LIM_L : ROM_LIM_S));
    ram_hit = !io_sel && (addr[ADDR_W-1:RAM_LSB] == RAM_BASE[ADDR_W-1:RAM_LSB]);
    io_hit  = io_sel && (addr[IO_W-1:IO_LSB] == IO_BASE[IO_W-1:IO_LSB]);
    hit     = rom_hit || ram_hit || io_hit;
  end

endmodule

// File: rtl/busrdy_fsm.sv
module busrdy_fsm
  import busrdy_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd,
  input  logic hit,
  input  logic rd_req,
  input  logic gnt_n,
  input  logic ack_n,
  output logic breq_n,
  output logic bpro_n,
  output logic drv_en_n,
  output logic rd_dir,
  output logic bus_done
);

  busrdy_st_e st_q, st_d;
  logic       rd_cap_q, rd_cap_d, rd_cap_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (cmd && !hit) st_d = ST_REQ;
      ST_REQ: begin
        if (!cmd)        st_d = ST_IDLE;
        else if (!gnt_n) st_d = ST_OWN;
      end
      ST_OWN:  if (!ack_n) st_d = ST_DONE;
      ST_DONE: if (!cmd)   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rd_cap_en = (st_q == ST_IDLE) && (st_d == ST_REQ);
    rd_cap_d  = rd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cap_q <= 1'b0;
    end else if (rd_cap_en) begin
      rd_cap_q <= rd_cap_d;
    end
  end

  logic own_bus;
  always_comb begin
    own_bus  = (st_q == ST_OWN) || (st_q == ST_DONE);
    breq_n   = (st_q == ST_IDLE);
    bpro_n   = (st_q != ST_IDLE);
    drv_en_n = !own_bus;
    rd_dir   = own_bus && rd_cap_q;
    bus_done = (st_q == ST_DONE);
  end

endmodule

// File: rtl/busrdy_ready.sv
module busrdy_ready (
  input  logic cmd,
  input  logic hit,
  input  logic bus_done,
  input  logic drv_en_n,
  input  logic ack_n,
  output logic ready
);

  logic remote_pending;
  logic bus_ctl;

  always_comb begin
    remote_pending = cmd && !hit;
    bus_ctl        = !drv_en_n;
    ready          = !remote_pending || bus_done || (bus_ctl && !ack_n);
  end

endmodule

// File: rtl/busrdy_ctrl.sv
module busrdy_ctrl #(
  parameter int              ADDR_W    = 16,
  parameter int              IO_W      = 8,
  parameter int              ROM_SMALL = 2048,
  parameter int              ROM_LARGE = 4096,
  parameter int              RAM_BYTES = 512,
  parameter logic [ADDR_W-1:0] RAM_BASE = 16'h3E00,
  parameter int              IO_SPAN   = 16,
  parameter logic [IO_W-1:0] IO_BASE   = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_sel,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              rom_big,
  input  logic              bus_gnt_n,
  input  logic              xfer_ack_n,
  output logic              cpu_ready,
  output logic              breq_n,
  output logic              bpro_n,
  output logic              drv_en_n,
  output logic              rd_dir
);

  logic cmd;
  logic onb_hit;
  logic bus_done;

  assign cmd = !rd_n || !wr_n;

  busrdy_decode #(
    .ADDR_W(ADDR_W), .IO_W(IO_W), .ROM_SMALL(ROM_SMALL), .ROM_LARGE(ROM_LARGE),
    .RAM_BYTES(RAM_BYTES), .RAM_BASE(RAM_BASE), .IO_SPAN(IO_SPAN), .IO_BASE(IO_BASE)
  ) u_dec (
    .addr    (addr),
    .io_sel  (io_sel),
    .rom_big (rom_big),
    .hit     (onb_hit)
  );

  busrdy_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .hit      (onb_hit),
    .rd_req   (!rd_n),
    .gnt_n    (bus_gnt_n),
    .ack_n    (xfer_ack_n),
    .breq_n   (breq_n),
    .bpro_n   (bpro_n),
    .drv_en_n (drv_en_n),
    .rd_dir   (rd_dir),
    .bus_done (bus_done)
  );

  busrdy_ready u_rdy (
    .cmd      (cmd),
    .hit      (onb_hit),
    .bus_done (bus_done),
    .drv_en_n (drv_en_n),
    .ack_n    (xfer_ack_n),
    .ready    (cpu_ready)
  );

endmodule

// File: rtl/busrdy_checker.sv
module busrdy_checker (
  input logic clk,
  input logic rst_n,
  input logic rd_n,
  input logic wr_n,
  input logic bus_gnt_n,
  input logic xfer_ack_n,
  input logic onb_hit,
  input logic cpu_ready,
  input logic breq_n,
  input logic bpro_n,
  input logic drv_en_n,
  input logic rd_dir
);

  logic cmd;
  assign cmd = !rd_n || !wr_n;

  logic acked_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acked_q <= 1'b0;
    end else if (drv_en_n) begin
      acked_q <= 1'b0;
    end else if (!xfer_ack_n) begin
      acked_q <= 1'b1;
    end
  end

  // R1, R2, R3: local hit never waits
  p_onboard_nowait_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && onb_hit) |-> cpu_ready);

  p_req_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(breq_n) |-> $past(cmd && !onb_hit));

  p_prio_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bpro_n) |-> $past(cmd && !onb_hit));

  p_wait_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!breq_n && drv_en_n && cmd && !onb_hit) |-> !cpu_ready);

  p_drv_on_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_en_n) |-> $past(!bus_gnt_n && !breq_n));

  p_ack_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_en_n && !xfer_ack_n) |-> cpu_ready);

  p_dir_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_dir) |-> ($past(!rd_n) && !drv_en_n));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en_n) |-> $past(acked_q));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(breq_n) |-> $past(!cmd));

  p_idle_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (breq_n && !cmd) |-> cpu_ready);

  p_withdraw_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!breq_n && drv_en_n && !cmd) |=> breq_n);

endmodule

bind busrdy_ctrl busrdy_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .bus_gnt_n  (bus_gnt_n),
  .xfer_ack_n (xfer_ack_n),
  .onb_hit    (onb_hit),
  .cpu_ready  (cpu_ready),
  .breq_n     (breq_n),
  .bpro_n     (bpro_n),
  .drv_en_n   (drv_en_n),
  .rd_dir     (rd_dir)
);

// File: tb/busrdy_ctrl_bench.sv
`timescale 1ns/1ps
module busrdy_ctrl_bench;

  localparam int RAM_LO  = 16'h3E00;
  localparam int RAM_SZ  = 512;
  localparam int IO_NIB  = 4'hE;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        io_sel, rd_n, wr_n, rom_big, bus_gnt_n, xfer_ack_n;
  logic        cpu_ready, breq_n, bpro_n, drv_en_n, rd_dir;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  busrdy_ctrl u_busrdy_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .io_sel(io_sel), .rd_n(rd_n),
    .wr_n(wr_n), .rom_big(rom_big), .bus_gnt_n(bus_gnt_n),
    .xfer_ack_n(xfer_ack_n), .cpu_ready(cpu_ready), .breq_n(breq_n),
    .bpro_n(bpro_n), .drv_en_n(drv_en_n), .rd_dir(rd_dir)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_checks(string tag);
    check({tag, " breq_n"}, breq_n, 1);
    check({tag, " bpro_n"}, bpro_n, 0);
    check({tag, " drv_en_n"}, drv_en_n, 1);
    check({tag, " rd_dir"}, rd_dir, 0);
  endtask

  function automatic int mem_hit(int a, int big);
    int lim = big ? 4096 : 2048;
    return ((a < lim) || (a >= RAM_LO && a < RAM_LO + RAM_SZ)) ? 1 : 0;
  endfunction

  // one probe: command for one clock, then withdrawn
  task automatic probe(int a, int io, int big, int exp_hit, string tag);
    step();
    addr = a[15:0]; io_sel = io[0]; rom_big = big[0]; rd_n = 1'b0;
    #1;
    check({tag, " ready"}, cpu_ready, exp_hit);
    step();
    rd_n = 1'b1;
    #1;
    check({tag, " R4 breq_n"}, breq_n, exp_hit);
  endtask

  initial begin
    rst_n = 1'b0; addr = 16'h0; io_sel = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    rom_big = 1'b0; bus_gnt_n = 1'b1; xfer_ack_n = 1'b1;
    repeat (3) step();
    #1;
    idle_checks("R10 reset");
    check("R10 reset ready", cpu_ready, 1);
    step();
    rst_n = 1'b1;
    step(); #1;
    idle_checks("R10 idle");
    addr = 16'h8000;
    #1;
    check("R10 idle remote addr no cmd ready", cpu_ready, 1);

    // R1 / R2 memory sweep, both ROM sizes
    for (int big = 0; big < 2; big++) begin
      for (int i = 0; i < 4096; i++) begin
        int a = i * 16 + (i % 16);
        probe(a, 0, big, mem_hit(a, big), "R1 R2 sweep");
      end
    end
    // window edges
    begin
      int edges [9] = '{16'h07FF, 16'h0800, 16'h0FFF, 16'h1000, 16'h3DFF,
                        16'h3E00, 16'h3FFF, 16'h4000, 16'h0000};
      for (int big = 0; big < 2; big++)
        for (int k = 0; k < 9; k++)
          probe(edges[k], 0, big, mem_hit(edges[k], big), "R1 R2 edge");
    end
    // R3 I/O sweep
    for (int v = 0; v < 256; v++) begin
      probe((v << 8) | v, 1, 0, ((v >> 4) == IO_NIB) ? 1 : 0, "R3 io sweep");
    end

    // remote read with grant and acknowledge delays
    step();
    io_sel = 1'b0; addr = 16'h8000; rd_n = 1'b0;
    #1;
    check("R4 read ready low", cpu_ready, 0);
    check("R4 read breq_n before clock", breq_n, 1);
    for (int w = 0; w < 2; w++) begin
      step(); #1;
      check("R4 read breq_n", breq_n, 0);
      check("R4 read bpro_n", bpro_n, 1);
      check("R5 no grant drv_en_n", drv_en_n, 1);
      check("R5 no grant ready", cpu_ready, 0);
    end
    step();
    bus_gnt_n = 1'b0;
    #1;
    check("R5 grant seen drv_en_n", drv_en_n, 1);
    step();
    bus_gnt_n = 1'b1;
    #1;
    check("R5 drivers on", drv_en_n, 0);
    check("R7 read dir", rd_dir, 1);
    check("R6 ready low no ack", cpu_ready, 0);
    for (int w = 0; w < 2; w++) begin
      step(); #1;
      check("R6 ready low waiting", cpu_ready, 0);
      check("R8 drivers held", drv_en_n, 0);
    end
    step();
    xfer_ack_n = 1'b0;
    #1;
    check("R6 ready on ack", cpu_ready, 1);
    step();
    xfer_ack_n = 1'b1;
    #1;
    check("R6 ready after ack", cpu_ready, 1);
    check("R9 breq_n held in command", breq_n, 0);
    check("R9 drivers held in command", drv_en_n, 0);
    step();
    rd_n = 1'b1;
    #1;
    check("R9 breq_n same cycle as end", breq_n, 0);
    check("R9 ready", cpu_ready, 1);
    step(); #1;
    idle_checks("R9 read release");

    // remote write, immediate grant and ack
    step();
    addr = 16'hC123; wr_n = 1'b0;
    #1;
    check("R4 write ready low", cpu_ready, 0);
    step();
    bus_gnt_n = 1'b0;
    #1;
    check("R4 write breq_n", breq_n, 0);
    step();
    bus_gnt_n = 1'b1; xfer_ack_n = 1'b0;
    #1;
    check("R5 write drivers on", drv_en_n, 0);
    check("R7 write dir", rd_dir, 0);
    check("R6 write ready on ack", cpu_ready, 1);
    step();
    xfer_ack_n = 1'b1; wr_n = 1'b1;
    #1;
    check("R9 write held", breq_n, 0);
    step(); #1;
    idle_checks("R9 write release");

    // R8: command removed before acknowledge
    step();
    addr = 16'h9000; wr_n = 1'b0;
    step();
    bus_gnt_n = 1'b0;
    step();
    bus_gnt_n = 1'b1; wr_n = 1'b1;
    #1;
    check("R8 drivers on", drv_en_n, 0);
    for (int w = 0; w < 3; w++) begin
      step(); #1;
      check("R8 drivers kept", drv_en_n, 0);
      check("R8 request kept", breq_n, 0);
    end
    step();
    xfer_ack_n = 1'b0;
    #1;
    check("R8 still on at ack", drv_en_n, 0);
    step();
    xfer_ack_n = 1'b1;
    #1;
    check("R8 one clock after ack", drv_en_n, 0);
    step(); #1;
    idle_checks("R8 release");

    // R11: withdrawal before grant, memory and I/O
    for (int io = 0; io < 2; io++) begin
      step();
      io_sel = io[0]; addr = 16'h4242; rd_n = 1'b0;
      #1;
      check("R4 abort ready low", cpu_ready, 0);
      step();
      rd_n = 1'b1;
      #1;
      check("R11 pending", breq_n, 0);
      step(); #1;
      idle_checks("R11 withdrawn");
      step(); #1;
      check("R11 drivers never on", drv_en_n, 1);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule